// File: doc/BRIEF.md
# Three-Bit Frame CRC Generator and Checker

This block computes and verifies the 3-bit CRC that protects 32-bit serial frames. It supports three protocol modes. In each mode the CRC starts from a different seed, runs over a different span of the frame, and compares against a received CRC field at a different position. The generator polynomial is x^3 + x + 1 in every mode.

Frame generation and checking are purely combinational. A frame word and a mode select go in. The block returns the CRC that belongs in the frame and a flag that says whether the CRC field already in the word is correct.

A small registered bit-serial engine shares the same polynomial and seeds. It lets a shifter accumulate the CRC one bit per cycle while a frame is still arriving.

Top module: `fcrc_unit`

## Requirements
- R1: Mode 2'b00 (out-of-frame) seeds the register with 101b and covers frame bits 31 down to 3. The received CRC sits in bits 2:0. `crc_o` is the remainder after the covered bits, taken MSB first, followed by three zero bits.
- R2: Mode 2'b01 (in-frame command) seeds with 111b and covers bits 31 down to 5. The received CRC sits in bits 4:2, and bits 1:0 are not used.
- R3: Mode 2'b10 (in-frame response) seeds with 111b and covers bits 26 down to 3. The received CRC sits in bits 2:0, and bits 31:27 are not used.
- R4: Mode 2'b11 is invalid. It forces `crc_o` to 000b and `crc_ok_o` to 0.
- R5: In a valid mode, `crc_ok_o` is 1 exactly when the register ends at 000b after running over the covered bits and then the received CRC field. This holds exactly when the field equals `crc_o`. Any single flipped covered bit clears the flag. Bits outside the covered span and the field have no effect.
- R6: These frames pass:
  - out-of-frame: 0x00000003, 0xFFFFFFF8, 0x0F0F0F0A, 0x0FF2C8FE
  - in-frame command: 0x00000004, 0xFFFFFFF7, 0x0F0F0F13, 0x0FF2C8E7
  - in-frame response: 0x00000006, 0xFFFFFFFC, 0x0F0F0F0A, 0x0FF2C8FE
- R7: 0x00000000, 0xFFFFFFFF, 0x0F0F0F0F and 0x0FF2C8FA fail in every mode.
- R8: `ser_start_i` loads the serial register with the seed of `mode_i` on the next clock edge, or with 000b for mode 2'b11. Start takes priority over `ser_valid_i`.
- R9: The serial register resets to 000b. Each cycle with `ser_valid_i` high and no start, it advances by one bit, `ser_bit_i`, using the same polynomial. Otherwise it holds.
  - Feeding the covered bits MSB first and then three zeros yields the R1–R3 CRC.
  - Feeding the covered bits and then a correct received field yields 000b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the serial engine |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Protocol mode select |
| frame_i | input | 32 | Frame word to protect or check |
| crc_o | output | 3 | CRC computed for the frame in the selected mode |
| crc_ok_o | output | 1 | Received CRC field is correct |
| ser_start_i | input | 1 | Load the serial register with the mode seed |
| ser_valid_i | input | 1 | Advance the serial register by one bit |
| ser_bit_i | input | 1 | Next frame bit, MSB first |
| ser_crc_o | output | 3 | Serial CRC register |

## Verification
The bench builds the block with its default 32-bit frame and 3-bit CRC, which are the only widths the modes define.

At these widths the full protocol behaviour is within reach. The bench sweeps thousands of pseudo-random words per mode and compares them against a long-division model. It also applies every stated pass and fail vector in every mode and corrupts each covered bit position in turn.

The serial engine is exercised per mode in both of its uses: generating a CRC and checking one to a zero remainder.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;
  localparam int FRAME_W = 32;
  localparam int CRC_W   = 3;
  localparam int POS_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    MODE_OOF = 2'b00,
    MODE_IFC = 2'b01,
    MODE_IFR = 2'b10,
    MODE_BAD = 2'b11
  } crc_mode_e;

  // x^3 + x + 1, top term implicit
  localparam logic [CRC_W-1:0] POLY     = 3'b011;
  localparam logic [CRC_W-1:0] SEED_OOF = 3'b101;
  localparam logic [CRC_W-1:0] SEED_IF  = 3'b111;

  typedef struct packed {
    logic             vld;
    logic [CRC_W-1:0] seed;
    logic [POS_W-1:0] hi;
    logic [POS_W-1:0] lo;
    logic [POS_W-1:0] fld_lo;
  } mode_cfg_t;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] r, logic b);
    return {r[CRC_W-2:0], b} ^ (r[CRC_W-1] ? POLY : '0);
  endfunction
endpackage

// File: rtl/fcrc_mode_dec.sv
module fcrc_mode_dec
  import fcrc_pkg::*;
(
  input  logic [1:0] mode_i,
  output mode_cfg_t  cfg_o
);
  always_comb begin
    cfg_o = '0;
    unique case (crc_mode_e'(mode_i))
      MODE_OOF: cfg_o = '{vld: 1'b1, seed: SEED_OOF, hi: POS_W'(31), lo: POS_W'(3), fld_lo: POS_W'(0)};
      MODE_IFC: cfg_o = '{vld: 1'b1, seed: SEED_IF,  hi: POS_W'(31), lo: POS_W'(5), fld_lo: POS_W'(2)};
      MODE_IFR: cfg_o = '{vld: 1'b1, seed: SEED_IF,  hi: POS_W'(26), lo: POS_W'(3), fld_lo: POS_W'(0)};
      default:  cfg_o = '0;
    endcase
  end
endmodule

// File: rtl/fcrc_span.sv
module fcrc_span
  import fcrc_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CRC_W,
  localparam int PW = $clog2(FW)
) (
  input  logic [FW-1:0] frame_i,
  input  logic [CW-1:0] seed_i,
  input  logic [PW-1:0] hi_i,
  input  logic [PW-1:0] lo_i,
  input  logic [PW-1:0] fld_lo_i,
  output logic [CW-1:0] crc_o,
  output logic [CW-1:0] syn_o
);
  logic [CW-1:0] st  [FW+1];
  logic [CW-1:0] aug [CW+1];
  logic [CW-1:0] chk [CW+1];
  logic [FW-1:0] shifted;
  logic [CW-1:0] rx;

  assign st[0] = seed_i;

  for (genvar k = 0; k < FW; k++) begin : g_bit
    localparam logic [PW-1:0] P = PW'(FW-1-k);
    assign st[k+1] = (P <= hi_i && P >= lo_i) ? crc_step(st[k], frame_i[FW-1-k]) : st[k];
  end

  assign shifted = frame_i >> fld_lo_i;
  assign rx      = shifted[CW-1:0];
  assign aug[0]  = st[FW];
  assign chk[0]  = st[FW];

  for (genvar j = 0; j < CW; j++) begin : g_tail
    assign aug[j+1] = crc_step(aug[j], 1'b0);
    assign chk[j+1] = crc_step(chk[j], rx[CW-1-j]);
  end

  assign crc_o = aug[CW];
  assign syn_o = chk[CW];
endmodule

// File: rtl/fcrc_serial.sv
module fcrc_serial
  import fcrc_pkg::*;
#(
  parameter int CW = CRC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic          bit_i,
  input  logic [CW-1:0] seed_i,
  output logic [CW-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= '0;
    else if (start_i) state_o <= seed_i;
    else if (valid_i) state_o <= crc_step(state_o, bit_i);
  end
endmodule

// File: rtl/fcrc_unit.sv
module fcrc_unit
  import fcrc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CRC_W-1:0]   crc_o,
  output logic               crc_ok_o,
  input  logic               ser_start_i,
  input  logic               ser_valid_i,
  input  logic               ser_bit_i,
  output logic [CRC_W-1:0]   ser_crc_o
);
  mode_cfg_t        cfg;
  logic [CRC_W-1:0] gen_crc;
  logic [CRC_W-1:0] syn;

  fcrc_mode_dec u_dec (
    .mode_i (mode_i),
    .cfg_o  (cfg)
  );

  fcrc_span #(.FW(FRAME_W), .CW(CRC_W)) u_span (
    .frame_i  (frame_i),
    .seed_i   (cfg.seed),
    .hi_i     (cfg.hi),
    .lo_i     (cfg.lo),
    .fld_lo_i (cfg.fld_lo),
    .crc_o    (gen_crc),
    .syn_o    (syn)
  );

  fcrc_serial #(.CW(CRC_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ser_start_i),
    .valid_i (ser_valid_i),
    .bit_i   (ser_bit_i),
    .seed_i  (cfg.seed),
    .state_o (ser_crc_o)
  );

  assign crc_o    = cfg.vld ? gen_crc : '0;
  assign crc_ok_o = cfg.vld && (syn == '0);
endmodule

// File: rtl/fcrc_unit_chk.sv
module fcrc_unit_chk
  import fcrc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         mode_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic [CRC_W-1:0]   crc_o,
  input logic               crc_ok_o,
  input logic               ser_start_i,
  input logic               ser_valid_i,
  input logic               ser_bit_i,
  input logic [CRC_W-1:0]   ser_crc_o
);
  logic [CRC_W-1:0] rx_fld;
  logic [CRC_W-1:0] exp_seed;

  assign rx_fld   = (mode_i == 2'b01) ? frame_i[4:2] : frame_i[2:0];
  assign exp_seed = (mode_i == 2'b11) ? 3'b000 : (mode_i == 2'b00) ? 3'b101 : 3'b111;

  // R4
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |-> !crc_ok_o && crc_o == 3'b000);

  // R5
  ok_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_ok_o |-> crc_o == rx_fld);

  // R8
  ser_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_start_i |=> ser_crc_o == $past(exp_seed));

  // R9
  ser_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_start_i && !ser_valid_i |=> $stable(ser_crc_o));

  // R9
  ser_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_start_i && ser_valid_i && !ser_crc_o[2] |=> ser_crc_o == {$past(ser_crc_o[1:0]), $past(ser_bit_i)});
endmodule

bind fcrc_unit fcrc_unit_chk u_chk (.*);

// File: tb/fcrc_unit_test.sv
module fcrc_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [31:0] frame_i = '0;
  logic [2:0]  crc_o;
  logic        crc_ok_o;
  logic        ser_start_i = 1'b0;
  logic        ser_valid_i = 1'b0;
  logic        ser_bit_i = 1'b0;
  logic [2:0]  ser_crc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  fcrc_unit uut (.*);

  function automatic int m_hi(int m); return (m == 2) ? 26 : 31; endfunction
  function automatic int m_lo(int m); return (m == 1) ? 5 : 3; endfunction
  function automatic int m_fld(int m); return (m == 1) ? 2 : 0; endfunction
  function automatic logic [2:0] m_seed(int m); return (m == 0) ? 3'b101 : 3'b111; endfunction

  // long division by 1011b, MSB first, seeded, with three zero bits appended
  function automatic logic [2:0] ref_crc(logic [31:0] f, int m);
    logic [3:0] r;
    r = {1'b0, m_seed(m)};
    for (int p = m_hi(m); p >= m_lo(m); p--) begin
      r = {r[2:0], f[p]};
      if (r[3]) r = r ^ 4'b1011;
    end
    for (int z = 0; z < 3; z++) begin
      r = {r[2:0], 1'b0};
      if (r[3]) r = r ^ 4'b1011;
    end
    return r[2:0];
  endfunction

  function automatic logic [31:0] put_fld(logic [31:0] f, int m, logic [2:0] c);
    logic [31:0] g;
    g = f;
    for (int i = 0; i < 3; i++) g[m_fld(m) + i] = c[i];
    return g;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (mode %0d frame %h)", req, act, exp, mode_i, frame_i);
    end
  endtask

  task automatic apply(int m, logic [31:0] f);
    @(negedge clk_i);
    mode_i  = 2'(m);
    frame_i = f;
    #2;
  endtask

  task automatic next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  task automatic ser_feed(int m, logic [31:0] f, bit use_fld, logic [2:0] exp, string req);
    @(negedge clk_i);
    mode_i = 2'(m);
    ser_start_i = 1'b1;
    @(negedge clk_i);
    ser_start_i = 1'b0;
    check("R8", 32'(ser_crc_o), 32'(m_seed(m)));
    for (int p = m_hi(m); p >= m_lo(m); p--) begin
      ser_valid_i = 1'b1;
      ser_bit_i   = f[p];
      @(negedge clk_i);
    end
    for (int i = 2; i >= 0; i--) begin
      ser_valid_i = 1'b1;
      ser_bit_i   = use_fld ? f[m_fld(m) + i] : 1'b0;
      @(negedge clk_i);
    end
    ser_valid_i = 1'b0;
    check(req, 32'(ser_crc_o), 32'(exp));
    @(negedge clk_i);
    check("R9 hold", 32'(ser_crc_o), 32'(exp));
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pass_v [3][4];
    logic [31:0] fail_v [4];
    pass_v[0] = '{32'h00000003, 32'hFFFFFFF8, 32'h0F0F0F0A, 32'h0FF2C8FE};
    pass_v[1] = '{32'h00000004, 32'hFFFFFFF7, 32'h0F0F0F13, 32'h0FF2C8E7};
    pass_v[2] = '{32'h00000006, 32'hFFFFFFFC, 32'h0F0F0F0A, 32'h0FF2C8FE};
    fail_v    = '{32'h00000000, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h0FF2C8FA};

    #25;
    check("R9 reset", 32'(ser_crc_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 reset", 32'(ser_crc_o), 32'h0);

    // R6 / R7 stated vectors
    for (int m = 0; m < 3; m++)
      for (int i = 0; i < 4; i++) begin
        apply(m, pass_v[m][i]);
        check("R6", 32'(crc_ok_o), 32'h1);
      end
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 4; i++) begin
        apply(m, fail_v[i]);
        check("R7", 32'(crc_ok_o), 32'h0);
      end

    // R1 R2 R3 R5 sweep
    for (int m = 0; m < 3; m++) begin
      int span;
      span = m_hi(m) - m_lo(m) + 1;
      for (int n = 0; n < 1500; n++) begin
        logic [2:0]  c;
        logic [31:0] g;
        next_rand();
        apply(m, lfsr);
        c = ref_crc(lfsr, m);
        check(m == 0 ? "R1" : m == 1 ? "R2" : "R3", 32'(crc_o), 32'(c));
        g = put_fld(lfsr, m, c);
        apply(m, g);
        check("R5 good", 32'(crc_ok_o), 32'h1);
        apply(m, g ^ (32'h1 << (m_lo(m) + (n % span))));
        check("R5 flip", 32'(crc_ok_o), 32'h0);
        apply(m, put_fld(lfsr, m, c ^ 3'(1 << (n % 3))));
        check("R5 field", 32'(crc_ok_o), 32'h0);
        if (m == 1) begin
          apply(m, g ^ (32'h1 << (n % 2)));
          check("R5 ignored", 32'(crc_ok_o), 32'h1);
        end
        if (m == 2) begin
          apply(m, g ^ (32'h1 << (27 + n % 5)));
          check("R5 ignored", 32'(crc_ok_o), 32'h1);
        end
      end
    end

    // R4 invalid mode
    for (int n = 0; n < 200; n++) begin
      next_rand();
      apply(3, lfsr);
      check("R4 crc", 32'(crc_o), 32'h0);
      check("R4 ok", 32'(crc_ok_o), 32'h0);
    end

    // R8 R9 serial engine
    for (int m = 0; m < 3; m++)
      for (int n = 0; n < 20; n++) begin
        logic [2:0] c;
        next_rand();
        c = ref_crc(lfsr, m);
        ser_feed(m, lfsr, 1'b0, c, "R9 gen");
        ser_feed(m, put_fld(lfsr, m, c), 1'b1, 3'b000, "R9 check");
      end

    // R8 start priority over valid, and invalid-mode seed
    @(negedge clk_i);
    mode_i = 2'b01; ser_start_i = 1'b1; ser_valid_i = 1'b1; ser_bit_i = 1'b1;
    @(negedge clk_i);
    check("R8 priority", 32'(ser_crc_o), 32'h7);
    mode_i = 2'b11;
    @(negedge clk_i);
    ser_start_i = 1'b0; ser_valid_i = 1'b0;
    check("R8 bad seed", 32'(ser_crc_o), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule